// File: doc/BRIEF.md
# Quad-Lane Serial Master Transmitter

This block is the sending half of a synchronous serial master. Software writes a character into a one-entry holding buffer. The engine moves it into a shift register and clocks it out on one, two or four data lines. It produces the serial clock itself by dividing the system clock. Two settings are programmed independently: the number of serial clock cycles per character, and the number of lanes used on each cycle.

The holding buffer is freed as soon as a character enters the shift register, so software can queue the next character while the current one is still being shifted. A character that is queued in time follows with no idle serial clock between them. When the last clock of a character finishes and nothing is queued, the clock stops and a sticky end-of-transfer flag is set. Each of the two status conditions can raise an interrupt line. The chip-select output follows a configuration bit directly.

Register map: address 0 is configuration. Its fields are lane mode [1:0], cycle count [5:2], lane direction [6], select [7] and divider [15:8]. Address 1 is transmit data. Address 2 is interrupt enable: bit 0 for buffer empty, bit 1 for end of transfer. Address 3 is status: bit 0 is buffer empty and bit 1 is end of transfer, and writing 1 to bit 1 clears it.

Top module: `qspi_tx_engine`

## Requirements
- R1: After reset:
  - `csN` is 1 and `sclk` is 0.
  - Both interrupt outputs are 0.
  - Status reads 1 (buffer empty, no end of transfer).
  - `dataOe` is 4'b0001.
- R2: A write to address 1 while the buffer is empty fills it, and the status buffer-empty bit drops to 0. On the next system clock edge the character moves to the shift register and buffer-empty returns to 1. When interrupt-enable bit 0 is 1, `irqBufEmpty` follows the buffer-empty bit in the same cycle.
- R3: Each character produces exactly (cycle count + 1) rising edges of `sclk`.
- R4: Lane mode selects the lanes. Code 0 uses one lane, code 1 uses two, code 2 uses four, and code 3 behaves as code 0.
  - A character is the low (cycle count + 1) × lanes bits of the written word, sent most significant bit first.
  - Each clock carries one group of bits. The highest bit of the group is on the highest-numbered lane used, so one lane uses line 0, two lanes use lines 1..0 and four lanes use lines 3..0.
- R5: The divider value D gives a serial clock period of 2×(D+1) system clocks. `sclk` is high for D+1 of them and low for D+1.
- R6: A character written while the previous one is still shifting follows it with no gap. The rising-edge spacing stays 2×(D+1), and end of transfer is flagged only after the last character.
- R7: End of transfer is set on the system edge where the last serial cycle of a character ends with the buffer empty. On that edge `sclk` goes to 0 and stays there. `irqTxEnd` is 1 when interrupt-enable bit 1 is 1. With D=0, the edge is 1+2×(cycle count+1) cycles after the write edge.
- R8: Writing 1 to status bit 1 clears end of transfer. Writing 0 to it leaves the flag unchanged.
- R9: Output enables depend on lane mode and the direction bit:
  - One lane (codes 0 and 3) drives `dataOe` = 4'b0001 whatever the direction bit.
  - Two lanes drive 4'b0011 and four lanes drive 4'b1111 when the direction bit is 0.
  - Two or four lanes drive 4'b0000 when the direction bit is 1.
- R10: `csN` is the inverse of configuration bit 7.
- R11: A write to address 1 while the buffer is full is dropped. The pending character, read back at address 1, is unchanged, and the dropped word is never sent.
- R12: `sclk` idles low. Data lines change only as `sclk` falls or as a character is loaded while `sclk` is low, so they are stable for the whole high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data, combinational from address |
| sclk | output | 1 | Serial clock, idle low |
| csN | output | 1 | Active-low chip select |
| dataOut | output | 4 | Serial data lines |
| dataOe | output | 4 | Per-line output enables |
| irqBufEmpty | output | 1 | Buffer-empty interrupt request |
| irqTxEnd | output | 1 | End-of-transfer interrupt request |

## Verification
All latencies are counted from the write edge.
- Buffer empty goes low just after that edge and returns to high one edge later, when the character loads.
- The first `sclk` rise comes D+1 cycles after the load.
- End of transfer appears 2×(cycle count+1)×(D+1) cycles after the load.
- Configuration and flag writes show at the ports just after their own edge.

The bench drives inputs at the falling system edge and reads outputs one time unit later. The single-cycle checks count exactly these edges. Serial data is captured by a monitor on each observed `sclk` rise, and the same monitor measures the spacing between rises and the rise on which end of transfer appeared.

// File: rtl/qspi_tx_pkg.sv
package qspi_tx_pkg;

  localparam int LANE_MAX = 4;

  // Register addresses
  localparam logic [1:0] ADDR_CFG  = 2'd0;
  localparam logic [1:0] ADDR_TXD  = 2'd1;
  localparam logic [1:0] ADDR_IEN  = 2'd2;
  localparam logic [1:0] ADDR_STAT = 2'd3;

  typedef enum logic [1:0] {
    LANE_ONE  = 2'd0,
    LANE_TWO  = 2'd1,
    LANE_FOUR = 2'd2,
    LANE_RSVD = 2'd3
  } laneMode_e;

  // Bit 1 of the encoding is the serial clock level itself.
  typedef enum logic [1:0] {
    PH_IDLE = 2'b00,
    PH_LOW  = 2'b01,
    PH_HIGH = 2'b10
  } phase_e;

  typedef struct packed {
    logic load;    // buffer -> shift register
    logic shift;   // advance one lane group
    logic setEnd;  // raise end-of-transfer flag
  } ctrlStrobe_t;

endpackage

// File: rtl/qspi_tx_ctrl.sv
module qspi_tx_ctrl
  import qspi_tx_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bufFull,
  input  logic [CNT_W-1:0]  cntField,
  input  logic [DIV_W-1:0]  divField,
  output ctrlStrobe_t       strobe,
  output logic              sclk
);

  phase_e             phase, phaseNext;
  logic [DIV_W-1:0]   halfCnt;
  logic [CNT_W-1:0]   cycleCnt;
  logic               halfDone;
  logic               lastCycle;

  assign halfDone  = (halfCnt >= divField);
  assign lastCycle = (cycleCnt >= cntField);
  assign sclk      = phase[1];

  always_comb begin
    strobe    = '0;
    phaseNext = phase;
    unique case (phase)
      PH_IDLE: begin
        if (bufFull) begin
          strobe.load = 1'b1;
          phaseNext   = PH_LOW;
        end
      end
      PH_LOW: begin
        if (halfDone) phaseNext = PH_HIGH;
      end
      PH_HIGH: begin
        if (halfDone) begin
          phaseNext = PH_LOW;
          if (!lastCycle) begin
            strobe.shift = 1'b1;
          end else if (bufFull) begin
            strobe.load = 1'b1;
          end else begin
            strobe.setEnd = 1'b1;
            phaseNext     = PH_IDLE;
          end
        end
      end
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      halfCnt  <= '0;
      cycleCnt <= '0;
    end else begin
      phase <= phaseNext;
      if (phaseNext != phase || phase == PH_IDLE) halfCnt <= '0;
      else                                        halfCnt <= halfCnt + 1'b1;
      if (strobe.load)       cycleCnt <= '0;
      else if (strobe.shift) cycleCnt <= cycleCnt + 1'b1;
    end
  end

  // A falling serial edge with a character waiting never idles the clock.
  assert_gapless_fall_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(sclk) && $past(bufFull)) |-> (phase == PH_LOW));

  // The clock never rises straight out of idle.
  assert_idle_low_R12: assert property (@(posedge clk) disable iff (!rstN)
    ($past(phase) == PH_IDLE) |-> !sclk);

endmodule

// File: rtl/qspi_tx_dpath.sv
module qspi_tx_dpath
  import qspi_tx_pkg::*;
#(
  parameter int REG_W = 32,
  parameter int CNT_W = 4,
  parameter int DIV_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [1:0]           regAddr,
  input  logic [REG_W-1:0]     regWrData,
  output logic [REG_W-1:0]     regRdData,
  input  ctrlStrobe_t          strobe,
  input  logic                 sclk,
  output logic                 bufFull,
  output logic [CNT_W-1:0]     cntField,
  output logic [DIV_W-1:0]     divField,
  output logic [LANE_MAX-1:0]  dataOut,
  output logic [LANE_MAX-1:0]  dataOe,
  output logic                 csN,
  output logic                 irqBufEmpty,
  output logic                 irqTxEnd
);

  localparam int SR_W    = (2 ** CNT_W) * LANE_MAX;
  localparam int SH_W    = $clog2(SR_W + 1);
  localparam int POS_CNT = 2;
  localparam int POS_DIR = POS_CNT + CNT_W;
  localparam int POS_SEL = POS_DIR + 1;
  localparam int POS_DIV = POS_SEL + 1;

  laneMode_e         cfgMode;
  logic [CNT_W-1:0]  cfgCnt;
  logic              cfgDirIn;
  logic              cfgSel;
  logic [DIV_W-1:0]  cfgDiv;
  logic [1:0]        irqEn;
  logic [REG_W-1:0]  txBuf;
  logic [SR_W-1:0]   shiftReg;
  logic              txEnd;

  logic              wrCfg, wrTxd, wrIen, wrStat, txAccept;
  logic [SH_W-1:0]   laneCnt;
  logic [SH_W-1:0]   charBits;
  logic [SH_W-1:0]   alignAmt;
  logic [SR_W-1:0]   loadImage;

  assign wrCfg    = regWrEn && (regAddr == ADDR_CFG);
  assign wrTxd    = regWrEn && (regAddr == ADDR_TXD);
  assign wrIen    = regWrEn && (regAddr == ADDR_IEN);
  assign wrStat   = regWrEn && (regAddr == ADDR_STAT);
  assign txAccept = wrTxd && !bufFull;

  // Lane width and character length
  always_comb begin
    unique case (cfgMode)
      LANE_TWO:  laneCnt = SH_W'(2);
      LANE_FOUR: laneCnt = SH_W'(4);
      default:   laneCnt = SH_W'(1);
    endcase
  end

  assign charBits  = (SH_W'(cfgCnt) + SH_W'(1)) * laneCnt;
  assign alignAmt  = SH_W'(SR_W) - charBits;
  assign loadImage = SR_W'(txBuf) << alignAmt;

  // Register and flag state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgMode  <= LANE_ONE;
      cfgCnt   <= '0;
      cfgDirIn <= 1'b0;
      cfgSel   <= 1'b0;
      cfgDiv   <= '0;
      irqEn    <= '0;
      txBuf    <= '0;
      bufFull  <= 1'b0;
      shiftReg <= '0;
      txEnd    <= 1'b0;
    end else begin
      if (wrCfg) begin
        cfgMode  <= laneMode_e'(regWrData[1:0]);
        cfgCnt   <= regWrData[POS_CNT +: CNT_W];
        cfgDirIn <= regWrData[POS_DIR];
        cfgSel   <= regWrData[POS_SEL];
        cfgDiv   <= regWrData[POS_DIV +: DIV_W];
      end
      if (wrIen) irqEn <= regWrData[1:0];

      if (txAccept) txBuf <= regWrData;
      if (strobe.load)   bufFull <= 1'b0;
      else if (txAccept) bufFull <= 1'b1;

      if (strobe.load)       shiftReg <= loadImage;
      else if (strobe.shift) shiftReg <= shiftReg << laneCnt;

      if (strobe.setEnd)              txEnd <= 1'b1;
      else if (wrStat && regWrData[1]) txEnd <= 1'b0;
    end
  end

  // Lane steering: highest group bit on highest-numbered lane in use
  always_comb begin
    dataOut = '0;
    dataOe  = '0;
    unique case (cfgMode)
      LANE_FOUR: begin
        dataOut = shiftReg[SR_W-1 -: 4];
        dataOe  = cfgDirIn ? 4'b0000 : 4'b1111;
      end
      LANE_TWO: begin
        dataOut[1:0] = shiftReg[SR_W-1 -: 2];
        dataOe       = cfgDirIn ? 4'b0000 : 4'b0011;
      end
      default: begin
        dataOut[0] = shiftReg[SR_W-1];
        dataOe     = 4'b0001;
      end
    endcase
  end

  // Register readback
  always_comb begin
    regRdData = '0;
    unique case (regAddr)
      ADDR_CFG: begin
        regRdData[1:0]               = cfgMode;
        regRdData[POS_CNT +: CNT_W]  = cfgCnt;
        regRdData[POS_DIR]           = cfgDirIn;
        regRdData[POS_SEL]           = cfgSel;
        regRdData[POS_DIV +: DIV_W]  = cfgDiv;
      end
      ADDR_TXD:  regRdData = txBuf;
      ADDR_IEN:  regRdData[1:0] = irqEn;
      default:   regRdData[1:0] = {txEnd, !bufFull};
    endcase
  end

  assign cntField    = cfgCnt;
  assign divField    = cfgDiv;
  assign csN         = !cfgSel;
  assign irqBufEmpty = irqEn[0] && !bufFull;
  assign irqTxEnd    = irqEn[1] && txEnd;

  assert_lanes_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    (sclk && $past(sclk)) |-> $stable(dataOut));

  assert_load_frees_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> !bufFull);

  assert_full_drop_R11: assert property (@(posedge clk) disable iff (!rstN)
    (wrTxd && bufFull) |=> $stable(txBuf));

  assert_end_clock_low_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txEnd) |-> !sclk);

  assert_end_needs_empty_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txEnd) |-> !$past(bufFull));

endmodule

// File: rtl/qspi_tx_engine.sv
module qspi_tx_engine
  import qspi_tx_pkg::*;
#(
  parameter int REG_W = 32,
  parameter int CNT_W = 4,
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  output logic              sclk,
  output logic              csN,
  output logic [3:0]        dataOut,
  output logic [3:0]        dataOe,
  output logic              irqBufEmpty,
  output logic              irqTxEnd
);

  ctrlStrobe_t       strobe;
  logic              bufFull;
  logic [CNT_W-1:0]  cntField;
  logic [DIV_W-1:0]  divField;

  qspi_tx_ctrl #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .bufFull  (bufFull),
    .cntField (cntField),
    .divField (divField),
    .strobe   (strobe),
    .sclk     (sclk)
  );

  qspi_tx_dpath #(.REG_W(REG_W), .CNT_W(CNT_W), .DIV_W(DIV_W)) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .regWrEn     (regWrEn),
    .regAddr     (regAddr),
    .regWrData   (regWrData),
    .regRdData   (regRdData),
    .strobe      (strobe),
    .sclk        (sclk),
    .bufFull     (bufFull),
    .cntField    (cntField),
    .divField    (divField),
    .dataOut     (dataOut),
    .dataOe      (dataOe),
    .csN         (csN),
    .irqBufEmpty (irqBufEmpty),
    .irqTxEnd    (irqTxEnd)
  );

endmodule

// File: tb/qspi_tx_engine_tb.sv
module qspi_tx_engine_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic        regWrEn;
  logic [1:0]  regAddr;
  logic [31:0] regWrData;
  logic [31:0] regRdData;
  logic        sclk, csN, irqBufEmpty, irqTxEnd;
  logic [3:0]  dataOut, dataOe;

  always #5 clk = ~clk;

  qspi_tx_engine u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .sclk(sclk), .csN(csN),
    .dataOut(dataOut), .dataOe(dataOe), .irqBufEmpty(irqBufEmpty),
    .irqTxEnd(irqTxEnd)
  );

  int checks = 0;
  int failures = 0;

  // {lane mode, cycle field, divider, data}
  localparam int NV = 8;
  localparam logic [45:0] VEC [NV] = '{
    {2'd0, 4'd7,  8'd0, 32'h000000A5},
    {2'd0, 4'd15, 8'd1, 32'h0000BEEF},
    {2'd1, 4'd3,  8'd0, 32'h000000C6},
    {2'd1, 4'd7,  8'd2, 32'h00001234},
    {2'd2, 4'd1,  8'd0, 32'h0000005A},
    {2'd2, 4'd3,  8'd0, 32'h00009C3E},
    {2'd2, 4'd7,  8'd1, 32'hDEADBEEF},
    {2'd0, 4'd3,  8'd0, 32'h000000F6}
  };

  // Serial capture monitor
  logic [63:0] recv;
  int riseCnt, minGap, maxGap, lastRise, cyc, endAtRise, tbLanes;
  logic prevSclk = 1'b0;
  logic prevEnd = 1'b0;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (sclk && !prevSclk) begin
      if (tbLanes == 4)      recv = (recv << 4) | 64'(dataOut);
      else if (tbLanes == 2) recv = (recv << 2) | 64'(dataOut[1:0]);
      else                   recv = (recv << 1) | 64'(dataOut[0]);
      if (riseCnt > 0) begin
        if (cyc - lastRise < minGap) minGap = cyc - lastRise;
        if (cyc - lastRise > maxGap) maxGap = cyc - lastRise;
      end
      lastRise = cyc;
      riseCnt  = riseCnt + 1;
    end
    if (irqTxEnd && !prevEnd) endAtRise = riseCnt;
    prevSclk = sclk;
    prevEnd  = irqTxEnd;
  end

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] v);
    regAddr = a;
    #1;
    v = regRdData;
  endtask

  task automatic clearMon();
    recv = '0; riseCnt = 0; minGap = 1000000; maxGap = 0; endAtRise = -1;
  endtask

  task automatic waitEnd(string req);
    int n = 0;
    while (!irqTxEnd && n < 20000) begin
      @(negedge clk);
      n++;
    end
    check({req, " end reached"}, 64'(irqTxEnd), 64'd1);
  endtask

  function automatic logic [31:0] mkCfg(int mode, int cnt, int dir, int sel, int div);
    return 32'((div << 8) | (sel << 7) | (dir << 6) | (cnt << 2) | mode);
  endfunction

  function automatic int lanesOf(int mode);
    return (mode == 2) ? 4 : ((mode == 1) ? 2 : 1);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog all-requirements actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] rv;
    cyc = 0; tbLanes = 1;
    clearMon();
    rstN = 1'b0; regWrEn = 1'b0; regAddr = 2'd0; regWrData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd3, rv);
    check("R1 status", 64'(rv), 64'd1);
    check("R1 csN", 64'(csN), 64'd1);
    check("R1 sclk", 64'(sclk), 64'd0);
    check("R1 irqs", 64'({irqBufEmpty, irqTxEnd}), 64'd0);
    check("R1 oe", 64'(dataOe), 64'h1);

    // Vector table: R3, R4, R5, R7 end, R10 select
    for (int i = 0; i < NV; i++) begin
      int m, c, d, n;
      logic [63:0] exp;
      m = int'(VEC[i][45:44]);
      c = int'(VEC[i][43:40]);
      d = int'(VEC[i][39:32]);
      tbLanes = lanesOf(m);
      n = (c + 1) * tbLanes;
      exp = 64'(VEC[i][31:0]) & ((64'd1 << n) - 64'd1);
      wr(2'd0, mkCfg(m, c, 0, 1, d));
      wr(2'd3, 32'd2);
      wr(2'd2, 32'd2);
      check("R10 csN asserted", 64'(csN), 64'd0);
      clearMon();
      wr(2'd1, VEC[i][31:0]);
      waitEnd("R7");
      #1;
      check("R4 serial data", recv, exp);
      check("R3 rising edges", 64'(riseCnt), 64'(c + 1));
      check("R5 min period", 64'(minGap), 64'(2 * (d + 1)));
      check("R5 max period", 64'(maxGap), 64'(2 * (d + 1)));
      check("R7 clock idle low", 64'(sclk), 64'd0);
    end

    // R2 and R7 exact timing: single lane, 4 cycles, divider 0
    tbLanes = 1;
    wr(2'd0, mkCfg(0, 3, 0, 1, 0));
    wr(2'd3, 32'd2);
    wr(2'd2, 32'd3);
    check("R2 empty irq idle", 64'(irqBufEmpty), 64'd1);
    wr(2'd1, 32'h9);
    check("R2 irq low after write", 64'(irqBufEmpty), 64'd0);
    @(negedge clk);
    check("R2 irq high after load", 64'(irqBufEmpty), 64'd1);
    repeat (7) @(negedge clk);
    check("R7 end not early", 64'(irqTxEnd), 64'd0);
    @(negedge clk);
    check("R7 end on time", 64'(irqTxEnd), 64'd1);
    check("R7 sclk low at end", 64'(sclk), 64'd0);

    // R8 write-one-to-clear
    wr(2'd3, 32'd0);
    rd(2'd3, rv);
    check("R8 write 0 keeps flag", 64'(rv[1]), 64'd1);
    wr(2'd3, 32'd2);
    rd(2'd3, rv);
    check("R8 write 1 clears flag", 64'(rv[1]), 64'd0);
    check("R8 irq cleared", 64'(irqTxEnd), 64'd0);

    // R6 back-to-back: quad, 2 cycles, divider 0
    tbLanes = 4;
    wr(2'd0, mkCfg(2, 1, 0, 1, 0));
    clearMon();
    wr(2'd1, 32'h3C);
    @(negedge clk);
    wr(2'd1, 32'hA7);
    waitEnd("R6");
    #1;
    check("R6 joined data", recv, 64'h3CA7);
    check("R6 max spacing", 64'(maxGap), 64'd2);
    check("R6 end after last rise", 64'(endAtRise), 64'd4);
    wr(2'd3, 32'd2);

    // R11 write while full is dropped: single, 8 cycles, divider 3
    tbLanes = 1;
    wr(2'd0, mkCfg(0, 7, 0, 1, 3));
    clearMon();
    wr(2'd1, 32'h81);
    @(negedge clk);
    wr(2'd1, 32'h42);
    wr(2'd1, 32'hFF);
    rd(2'd1, rv);
    check("R11 pending kept", 64'(rv), 64'h42);
    waitEnd("R11");
    #1;
    check("R11 dropped not sent", recv, 64'h8142);
    check("R11 edge count", 64'(riseCnt), 64'd16);
    wr(2'd3, 32'd2);

    // R9 output enables across modes and direction
    for (int k = 0; k < 8; k++) begin
      int m, dir;
      logic [3:0] expOe;
      m = k / 2; dir = k % 2;
      if (m == 2)      expOe = dir ? 4'b0000 : 4'b1111;
      else if (m == 1) expOe = dir ? 4'b0000 : 4'b0011;
      else             expOe = 4'b0001;
      wr(2'd0, mkCfg(m, 3, dir, 1, 0));
      #1;
      check("R9 output enable", 64'(dataOe), 64'(expOe));
    end

    // R10 select follows configuration bit
    wr(2'd0, mkCfg(0, 3, 0, 0, 0));
    #1;
    check("R10 csN negated", 64'(csN), 64'd1);
    wr(2'd0, mkCfg(0, 3, 0, 1, 0));
    #1;
    check("R10 csN asserted", 64'(csN), 64'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule